// File: doc/BRIEF.md
# SRAM Clock Mode and DLL Lock Controller

This block holds the clock-control state of a synchronous SRAM with separate read and write ports. It runs on a free-running reference clock. A one-cycle strobe, `kclk_edge`, marks each edge of the SRAM input clock, and the two output-clock pins arrive as sampled levels.

Soon after power-up reset is released, the block fixes the device's clock mode and never changes it afterwards. If both output-clock pins are high, it picks single-clock mode, where output timing comes from the input clock alone. Otherwise it picks dual-clock mode, where skew compensation through the output clocks is allowed.

The block also tracks DLL lock. It counts input clock edges up to a fixed relock length. A watchdog on the reference clock notices when the input clock has gone missing and fires a DLL reset pulse, which discards any lock progress. A stop-clock request places the DLL in a deliberate stopped state: lock is dropped and the watchdog stays quiet. The echo-clock enable runs freely whenever the DLL is locked and no stop is requested.

Top module: `sram_clkmode_ctl`

## Requirements
- R1: `single_mode` reads 0 from reset until the first reference cycle in which `kclk_edge` is sampled high after `rst_n` rises. In that cycle the block samples the pins, and `single_mode` becomes 1 exactly when `oclk_p_lvl` and `oclk_n_lvl` were both 1. The levels must have been held for at least PIN_SYNC reference cycles beforehand.
- R2: Once the mode has been sampled, `single_mode` never changes until the next reset, whatever the output-clock pins do later.
- R3: While `stop_req` is 1, `dll_locked` is 0 from the following cycle, `dll_rst` stays 0, and lock progress is discarded. After release, a full LOCK_CYCLES edges are needed again.
- R4: `dll_locked` rises in the cycle after the LOCK_CYCLES-th (default 1024) `kclk_edge` counted since reset, stop or clock loss. It stays 0 after LOCK_CYCLES-1 edges.
- R5: After LOSS_LIMIT (default 16) consecutive reference cycles with `kclk_edge` low, `dll_rst` is 1 for exactly one cycle. The pulse repeats every LOSS_LIMIT cycles while edges stay absent. An edge restarts the count.
- R6: In the cycle after a `dll_rst` pulse, `dll_locked` is 0 and lock progress restarts from zero.
- R7: `echo_en` is 1 exactly when `dll_locked` is 1 and `stop_req` is 0. It drops in the same cycle that `stop_req` rises.
- R8: While `rst_n` is 0, `single_mode`, `dll_locked`, `dll_rst`, `echo_en` and `deskew_en` are all 0.
- R9: `deskew_en` is 1 only in dual-clock mode (`single_mode` 0), after the mode has been sampled and while `dll_locked` is 1. In single-clock mode it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Power-up reset, active low |
| kclk_edge | input | 1 | One-cycle strobe per input clock edge |
| oclk_p_lvl | input | 1 | Sampled level of output clock pin, true side |
| oclk_n_lvl | input | 1 | Sampled level of output clock pin, complement side |
| stop_req | input | 1 | Stop-clock request |
| single_mode | output | 1 | 1 = single-clock mode latched |
| dll_locked | output | 1 | DLL relock complete |
| dll_rst | output | 1 | One-cycle DLL reset pulse on clock loss |
| echo_en | output | 1 | Echo clock pair enable |
| deskew_en | output | 1 | Output-clock skew compensation allowed |

## Verification
The mode sample is tried with all four pin combinations at the first edge. Each combination is followed by all four combinations at later edges, which separates a correct one-time latch from a transparent one and from an AND that reads the wrong pins.

Edge gaps from 1 to 32 idle cycles are swept from a locked state. The sweep places the loss pulse on exactly the 16th idle cycle, shows that it lasts one cycle, and shows that it repeats at the 32nd.

Relock is measured at 1023 and at 1024 edges. This is done after reset, after a loss and after a stop, in both clock modes, so an off-by-one count is caught. It also catches a counter that does not restart when interrupted, and a skew enable that ignores the mode.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
   typedef enum logic {
      CKM_DUAL   = 1'b0,
      CKM_SINGLE = 1'b1
   } ckm_mode_e;

   // Single-clock mode needs both output clock pins held high.
   function automatic ckm_mode_e ckm_decode(input logic pin_p, input logic pin_n);
      return (pin_p && pin_n) ? CKM_SINGLE : CKM_DUAL;
   endfunction
endpackage

// File: rtl/ckm_pin_sync.sv
module ckm_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pins_i,
   output logic [1:0] pins_o
);
   generate
      if (STAGES == 0) begin : g_direct
         assign pins_o = pins_i;
      end else begin : g_chain
         logic [1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= pins_i;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign pins_o = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ckm_mode_latch.sv
module ckm_mode_latch
   import ckm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       edge_i,
   input  logic [1:0] pins_i,
   output ckm_mode_e  mode_o,
   output logic       done_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= CKM_DUAL;
         done_o <= 1'b0;
      end else if (edge_i && !done_o) begin
         mode_o <= ckm_decode(pins_i[1], pins_i[0]);
         done_o <= 1'b1;
      end
   end
endmodule

// File: rtl/ckm_loss_watch.sv
module ckm_loss_watch #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic stop_i,
   output logic loss_o
);
   localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] idle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
         loss_o   <= 1'b0;
      end else begin
         loss_o <= 1'b0;
         if (stop_i || edge_i) begin
            idle_cnt <= '0;
         end else if (idle_cnt == LAST) begin
            idle_cnt <= '0;
            loss_o   <= 1'b1;
         end else begin
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ckm_relock.sv
module ckm_relock #(
   parameter int CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic clear_i,
   output logic locked_o
);
   localparam int W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [W-1:0] LAST = W'(CYCLES - 1);

   logic [W-1:0] edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         locked_o <= 1'b0;
      end else if (clear_i) begin
         edge_cnt <= '0;
         locked_o <= 1'b0;
      end else if (edge_i && !locked_o) begin
         if (edge_cnt == LAST) locked_o <= 1'b1;
         else                  edge_cnt <= edge_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sram_clkmode_ctl.sv
module sram_clkmode_ctl
   import ckm_pkg::*;
#(
   parameter int LOCK_CYCLES = 1024,
   parameter int LOSS_LIMIT  = 16,
   parameter int PIN_SYNC    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kclk_edge,
   input  logic oclk_p_lvl,
   input  logic oclk_n_lvl,
   input  logic stop_req,
   output logic single_mode,
   output logic dll_locked,
   output logic dll_rst,
   output logic echo_en,
   output logic deskew_en
);
   generate
      if (LOCK_CYCLES < 2) begin : g_bad_lock
         $error("LOCK_CYCLES must be at least 2");
      end
      if (LOSS_LIMIT < 2) begin : g_bad_loss
         $error("LOSS_LIMIT must be at least 2");
      end
      if (PIN_SYNC < 0 || PIN_SYNC > 4) begin : g_bad_sync
         $error("PIN_SYNC must lie in 0..4");
      end
   endgenerate

   logic [1:0] pins_s;
   ckm_mode_e  mode_q;
   logic       mode_done;
   logic       lock_clear;

   ckm_pin_sync #(.STAGES(PIN_SYNC)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i ({oclk_p_lvl, oclk_n_lvl}),
      .pins_o (pins_s)
   );

   ckm_mode_latch u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (kclk_edge),
      .pins_i (pins_s),
      .mode_o (mode_q),
      .done_o (mode_done)
   );

   ckm_loss_watch #(.LIMIT(LOSS_LIMIT)) u_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (kclk_edge),
      .stop_i (stop_req),
      .loss_o (dll_rst)
   );

   assign lock_clear = stop_req | dll_rst;

   ckm_relock #(.CYCLES(LOCK_CYCLES)) u_relock (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_i   (kclk_edge),
      .clear_i  (lock_clear),
      .locked_o (dll_locked)
   );

   assign single_mode = (mode_q == CKM_SINGLE);
   assign echo_en     = dll_locked & ~stop_req;
   assign deskew_en   = mode_done & (mode_q == CKM_DUAL) & dll_locked;
endmodule

// File: rtl/ckm_checker.sv
module ckm_checker (
   input logic clk,
   input logic rst_n,
   input logic kclk_edge,
   input logic stop_req,
   input logic single_mode,
   input logic mode_done,
   input logic dll_locked,
   input logic dll_rst,
   input logic echo_en,
   input logic deskew_en
);
   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_done && $past(mode_done)) |-> $stable(single_mode)); // R2
   AST_STOP_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !dll_locked); // R3
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !dll_rst); // R3
   AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dll_locked) |-> ($past(kclk_edge) && !$past(stop_req))); // R4
   AST_LOSS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dll_rst |=> !dll_rst); // R5
   AST_LOSS_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      dll_rst |-> !$past(kclk_edge)); // R5
   AST_LOSS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      dll_rst |=> !dll_locked); // R6
   AST_ECHO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!dll_locked || stop_req) |-> !echo_en); // R7
   AST_DESKEW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      single_mode |-> !deskew_en); // R9
endmodule

bind sram_clkmode_ctl ckm_checker u_ckm_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .kclk_edge   (kclk_edge),
   .stop_req    (stop_req),
   .single_mode (single_mode),
   .mode_done   (mode_done),
   .dll_locked  (dll_locked),
   .dll_rst     (dll_rst),
   .echo_en     (echo_en),
   .deskew_en   (deskew_en)
);

// File: tb/tb_sram_clkmode_ctl.sv
`timescale 1ns/1ps
module tb_sram_clkmode_ctl;
   localparam int LOCKN = 1024;
   localparam int LOSSN = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kclk_edge = 1'b0;
   logic oclk_p_lvl = 1'b0;
   logic oclk_n_lvl = 1'b0;
   logic stop_req = 1'b0;
   logic single_mode, dll_locked, dll_rst, echo_en, deskew_en;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sram_clkmode_ctl dut (
      .clk(clk), .rst_n(rst_n), .kclk_edge(kclk_edge),
      .oclk_p_lvl(oclk_p_lvl), .oclk_n_lvl(oclk_n_lvl), .stop_req(stop_req),
      .single_mode(single_mode), .dll_locked(dll_locked), .dll_rst(dll_rst),
      .echo_en(echo_en), .deskew_en(deskew_en)
   );

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
         report();
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // Drive one reference cycle; outputs are sampled on the following falling edge.
   task automatic step(input bit e);
      kclk_edge = e;
      @(posedge clk);
      @(negedge clk);
      kclk_edge = 1'b0;
   endtask

   task automatic pump(input int n);
      for (int i = 0; i < n; i++) begin
         step(1'b1);
         step(1'b0);
      end
   endtask

   task automatic do_reset(input bit p, input bit q);
      rst_n = 1'b0;
      stop_req = 1'b0;
      oclk_p_lvl = p;
      oclk_n_lvl = q;
      for (int i = 0; i < 4; i++) step(1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) step(1'b0);
   endtask

   initial begin
      @(negedge clk);
      // R8: outputs during reset
      rst_n = 1'b0;
      oclk_p_lvl = 1'b1;
      oclk_n_lvl = 1'b1;
      for (int i = 0; i < 3; i++) step(1'b1);
      chk("R8 single_mode", single_mode, 0);
      chk("R8 dll_locked", dll_locked, 0);
      chk("R8 dll_rst", dll_rst, 0);
      chk("R8 echo_en", echo_en, 0);
      chk("R8 deskew_en", deskew_en, 0);

      // R1 and R2: every first-sample pattern, then every later pattern
      for (int m = 0; m < 4; m++) begin
         do_reset(m[1], m[0]);
         chk("R1 before sample", single_mode, 0);
         pump(1);
         chk("R1 sampled mode", single_mode, (m == 3) ? 1 : 0);
         for (int q = 0; q < 4; q++) begin
            oclk_p_lvl = q[1];
            oclk_n_lvl = q[0];
            for (int k = 0; k < 3; k++) step(1'b0);
            pump(1);
            chk("R2 mode frozen", single_mode, (m == 3) ? 1 : 0);
         end
      end

      // R4, R7, R9: relock length in dual-clock mode
      do_reset(1'b0, 1'b0);
      pump(LOCKN - 1);
      chk("R4 unlocked at 1023", dll_locked, 0);
      chk("R7 echo off while unlocked", echo_en, 0);
      pump(1);
      chk("R4 locked at 1024", dll_locked, 1);
      chk("R7 echo on when locked", echo_en, 1);
      chk("R9 deskew in dual mode", deskew_en, 1);

      // R5, R6, R7: idle-gap sweep from locked state
      step(1'b1);
      for (int i = 1; i <= 2 * LOSSN; i++) begin
         step(1'b0);
         chk("R5 loss pulse position", dll_rst, (i % LOSSN == 0) ? 1 : 0);
         if (i <= LOSSN) chk("R6 locked before loss", dll_locked, 1);
         else            chk("R6 unlocked after loss", dll_locked, 0);
         if (i == LOSSN + 1) chk("R7 echo off after loss", echo_en, 0);
      end
      // R6: progress restarts after loss
      step(1'b0);
      pump(LOCKN - 1);
      chk("R6 relock not early", dll_locked, 0);
      pump(1);
      chk("R6 relock after loss", dll_locked, 1);

      // R3, R7, R9: stop request in single-clock mode
      do_reset(1'b1, 1'b1);
      pump(LOCKN);
      chk("R9 locked single mode", dll_locked, 1);
      chk("R9 no deskew in single mode", deskew_en, 0);
      chk("R1 single latched", single_mode, 1);
      stop_req = 1'b1;
      #1;
      chk("R7 echo drops with stop", echo_en, 0);
      begin
         int pulses = 0;
         for (int i = 0; i < 3 * LOSSN; i++) begin
            step(1'b0);
            if (dll_rst) pulses++;
         end
         chk("R3 no loss pulse while stopped", pulses, 0);
      end
      chk("R3 unlocked while stopped", dll_locked, 0);
      stop_req = 1'b0;
      pump(LOCKN - 1);
      chk("R3 relock not early", dll_locked, 0);
      pump(1);
      chk("R3 relock after stop", dll_locked, 1);
      chk("R7 echo back after relock", echo_en, 1);

      // R3: interrupted progress is discarded
      stop_req = 1'b1;
      step(1'b0);
      stop_req = 1'b0;
      pump(LOCKN / 2);
      stop_req = 1'b1;
      step(1'b0);
      stop_req = 1'b0;
      pump(LOCKN - 1);
      chk("R3 count restarted", dll_locked, 0);
      pump(1);
      chk("R3 full count locks", dll_locked, 1);

      done = 1'b1;
      report();
      $finish;
   end
endmodule